// File: doc/BRIEF.md
# Word-Parallel CRC-32 Generator

This block computes a 32-bit cyclic redundancy check over a message that arrives as 64-bit words, one word per clock. The whole word is folded into the remainder in one combinational step. That step is a precomputed linear map: the bit-serial shift-register recursion is unrolled 64 times, and its effect on every state bit and every input bit is worked out when the design is elaborated. The default generator is the Ethernet CRC-32 polynomial 0x04C11DB7.

The remainder is formed in augmented-message form. The state starts at zero, with no initial inversion and no final XOR. After the final word, the block pushes 32 zero bits through a second, 32-step copy of the same map in one extra cycle. It then reports the result. A message of N words therefore gives its CRC after N+1 clock edges, which is (k+m)/w rounded up to whole words.

A user pulses the start input and presents words with a valid strobe. The user marks the final word with the last flag and waits for the single-cycle done pulse. The remainder stays on the output until the next start.

Top module: `crc_word_gen`

## Requirements
- R1: While reset is applied and after it is released, crc_o is all zeros and done_o is low.
- R2: A clock edge that samples start_i high sets crc_o to zero and done_o low. A data word presented with valid_i in that same cycle is not folded in.
- R3: In the message phase, each edge that samples valid_i high folds all 64 bits of data_i into the state. Bit 63 enters first and bit 0 last. Each bit follows the serial rule: the state shifts left by one, the message bit enters bit 0, and the result is XORed with 0x04C11DB7 when the bit shifted out of bit 31 was 1.
- R4: In the message phase, an edge that samples valid_i low leaves crc_o unchanged.
- R5: The edge after the one that accepts a word marked by last_i pushes 32 zero bits through the state. The same edge raises done_o, after which crc_o equals M(x)·x^32 mod G(x) for the message M.
- R6: done_o is high for exactly one clock cycle per completed message.
- R7: After done_o rises, crc_o holds its value and valid_i and last_i have no effect until the next start.
- R8: After reset and before the first start, words presented with valid_i have no effect and crc_o stays zero.
- R9: A start during an unfinished message discards the partial remainder. The next message is computed from a zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Clears the state and opens a new message |
| valid_i | input | 1 | data_i holds a message word this cycle |
| last_i | input | 1 | The word presented with valid_i is the final word |
| data_i | input | 64 | Message word, bit 63 first in time |
| done_o | output | 1 | One-cycle pulse: crc_o holds the finished remainder |
| crc_o | output | 32 | Current remainder, final after done_o |

## Verification
The bench runs messages of one to seven random words, with and without idle gaps between words. A gap that was absorbed as a zero word would corrupt the remainder, and a reversed bit order within the word would mismatch on the first word. It places the start pulse on the same cycle as a valid word, restarts in the middle of a message, and feeds words both before the first start and after done_o. A design that absorbed any of those words, or kept a partial state, would show a changed crc_o on the next compare. It checks when done_o rises and how long it lasts. Done asserted before the padding cycle, or padding with 64 zero bits instead of 32, would report the wrong remainder or the wrong cycle.

// File: rtl/crc_word_gen_pkg.sv
package crc_word_gen_pkg;

  // Ethernet CRC-32 generator polynomial, x^32 term implied
  localparam logic [31:0] CRC32_POLY = 32'h04C1_1DB7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MSG  = 2'd1,
    PH_PAD  = 2'd2,
    PH_DONE = 2'd3
  } crc_phase_e;

endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/crc_fmatrix.sv
// Applies DIN_W serial LFSR steps in one combinational pass. The map is
// linear, so each state bit and each input bit owns one column of the
// unrolled matrix; the columns are computed at elaboration.
module crc_fmatrix #(
  parameter int              CRC_W = 32,
  parameter int              DIN_W = 64,
  parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic [CRC_W-1:0] state_i,
  input  logic [DIN_W-1:0] din_i,
  output logic [CRC_W-1:0] state_o
);

  localparam logic [CRC_W-1:0] UNIT_S = {{(CRC_W-1){1'b0}}, 1'b1};
  localparam logic [DIN_W-1:0] UNIT_D = {{(DIN_W-1){1'b0}}, 1'b1};

  // Serial reference recursion, evaluated only for constant columns
  function automatic logic [CRC_W-1:0] walk(input logic [CRC_W-1:0] s,
                                            input logic [DIN_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = s;
    for (int i = DIN_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1];
      r  = {r[CRC_W-2:0], d[i]};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  logic [CRC_W-1:0] s_term [CRC_W];
  logic [CRC_W-1:0] d_term [DIN_W];

  for (genvar j = 0; j < CRC_W; j++) begin : g_scol
    localparam logic [CRC_W-1:0] COL = walk(UNIT_S << j, '0);
    assign s_term[j] = state_i[j] ? COL : '0;
  end

  for (genvar i = 0; i < DIN_W; i++) begin : g_dcol
    localparam logic [CRC_W-1:0] COL = walk('0, UNIT_D << i);
    assign d_term[i] = din_i[i] ? COL : '0;
  end

  always_comb begin
    state_o = '0;
    for (int j = 0; j < CRC_W; j++) state_o = state_o ^ s_term[j];
    for (int i = 0; i < DIN_W; i++) state_o = state_o ^ d_term[i];
  end

endmodule

// File: rtl/crc_seq.sv
module crc_seq
  import crc_word_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  input  logic last_i,
  output logic clear_o,
  output logic absorb_o,
  output logic pad_o,
  output logic done_o
);

  crc_phase_e phase_q;
  crc_phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (start_i) begin
      phase_d = PH_MSG;
    end else begin
      unique case (phase_q)
        PH_MSG:  if (valid_i && last_i) phase_d = PH_PAD;
        PH_PAD:  phase_d = PH_DONE;
        PH_DONE: phase_d = PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign clear_o  = start_i;
  assign absorb_o = !start_i && (phase_q == PH_MSG) && valid_i;
  assign pad_o    = !start_i && (phase_q == PH_PAD);
  assign done_o   = (phase_q == PH_DONE);

endmodule

// File: rtl/crc_word_gen.sv
module crc_word_gen
  import crc_word_gen_pkg::*;
#(
  parameter int               CRC_W       = 32,
  parameter int               WORD_W      = 64,
  parameter logic [CRC_W-1:0] POLY        = CRC32_POLY,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              done_o,
  output logic [CRC_W-1:0]  crc_o
);

  localparam int AUG_W = CRC_W;  // zero bits appended after the message

  logic             rst_n_int;
  logic             clear;
  logic             absorb;
  logic             pad;
  logic             state_en;
  logic [CRC_W-1:0] state_q;
  logic [CRC_W-1:0] state_d;
  logic [CRC_W-1:0] word_nxt;
  logic [CRC_W-1:0] pad_nxt;

  crc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  crc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (start_i),
    .valid_i  (valid_i),
    .last_i   (last_i),
    .clear_o  (clear),
    .absorb_o (absorb),
    .pad_o    (pad),
    .done_o   (done_o)
  );

  crc_fmatrix #(.CRC_W(CRC_W), .DIN_W(WORD_W), .POLY(POLY)) u_word (
    .state_i (state_q),
    .din_i   (data_i),
    .state_o (word_nxt)
  );

  crc_fmatrix #(.CRC_W(CRC_W), .DIN_W(AUG_W), .POLY(POLY)) u_pad (
    .state_i (state_q),
    .din_i   ({AUG_W{1'b0}}),
    .state_o (pad_nxt)
  );

  assign state_en = clear || absorb || pad;

  always_comb begin
    state_d = state_q;
    if (clear)       state_d = '0;
    else if (absorb) state_d = word_nxt;
    else if (pad)    state_d = pad_nxt;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign crc_o = state_q;

endmodule

// File: rtl/crc_word_gen_chk.sv
module crc_word_gen_chk #(
  parameter int CRC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             valid_i,
  input logic             last_i,
  input logic             done_o,
  input logic [CRC_W-1:0] crc_o
);

  logic msg_q;    // a message is open
  logic pad_q;    // last word was accepted on the previous edge
  logic seen_q;   // done has been reported since the last start
  logic take_last;

  assign take_last = msg_q && valid_i && last_i && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q  <= 1'b0;
      pad_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      msg_q  <= start_i ? 1'b1 : (take_last ? 1'b0 : msg_q);
      pad_q  <= take_last;
      seen_q <= start_i ? 1'b0 : (done_o ? 1'b1 : seen_q);
    end
  end

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (crc_o == '0) && !done_o);

  a_r4_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_q && !valid_i && !start_i) |=> $stable(crc_o));

  a_r5_done_after_pad: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(take_last, 2));

  a_r5_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    take_last |=> !done_o);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_o || seen_q) && !start_i) |=> $stable(crc_o));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_q && !pad_q && !start_i) |=> $stable(crc_o));

endmodule

bind crc_word_gen crc_word_gen_chk #(.CRC_W(CRC_W)) u_chk (.*);

// File: tb/crc_word_gen_bench.sv
module crc_word_gen_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] GEN_POLY   = 32'h04C1_1DB7;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        valid_i;
  logic        last_i;
  logic [63:0] data_i;
  logic        done_o;
  logic [31:0] crc_o;

  crc_word_gen u_crc_word_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_i (valid_i),
    .last_i  (last_i),
    .data_i  (data_i),
    .done_o  (done_o),
    .crc_o   (crc_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests;
  int n_fail;
  bit finished;
  bit cmp_en;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] r, input bit b);
    bit top;
    top = r[31];
    r = (r << 1) | {31'b0, b};
    if (top) r = r ^ GEN_POLY;
    return r;
  endfunction

  // Behavioural reference: phase as an integer, bits through a queue
  int          m_ph;   // 0 idle, 1 message, 2 padding, 3 done
  logic [31:0] m_crc;
  bit          m_done;
  bit          m_bits[$];

  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] t;
    if (!rst_n) begin
      m_ph   <= 0;
      m_crc  <= '0;
      m_done <= 1'b0;
    end else if (start_i) begin
      m_ph   <= 1;
      m_crc  <= '0;
      m_done <= 1'b0;
    end else begin
      m_done <= 1'b0;
      t = m_crc;
      if (m_ph == 1 && valid_i) begin
        for (int b = 63; b >= 0; b--) m_bits.push_back(data_i[b]);
        while (m_bits.size() > 0) t = step(t, m_bits.pop_front());
        m_crc <= t;
        if (last_i) m_ph <= 2;
      end else if (m_ph == 2) begin
        for (int b = 0; b < 32; b++) m_bits.push_back(1'b0);
        while (m_bits.size() > 0) t = step(t, m_bits.pop_front());
        m_crc  <= t;
        m_ph   <= 3;
        m_done <= 1'b1;
      end else if (m_ph == 3) begin
        m_ph <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(crc_o === m_crc, "R3", "crc_o vs reference", {32'b0, crc_o}, {32'b0, m_crc});
      chk(done_o === m_done, "R6", "done_o vs reference", {63'b0, done_o}, {63'b0, m_done});
    end
  end

  task automatic drive(input bit s, input bit v, input bit l, input logic [63:0] d);
    start_i = s;
    valid_i = v;
    last_i  = l;
    data_i  = d;
  endtask

  // Full message: start, nw words with optional gaps, then done checks
  task automatic send(input int nw, input int gap_pct, input bit junk_at_start,
                      output logic [31:0] gold);
    logic [63:0] w;
    logic [31:0] held;
    bit          pend;
    gold = '0;
    pend = 1'b0;
    held = '0;
    @(negedge clk);
    drive(1'b1, junk_at_start, 1'b0, {$urandom, $urandom});
    if (junk_at_start) begin
      @(negedge clk);
      chk(crc_o == '0, "R2", "word beside start absorbed", {32'b0, crc_o}, 64'b0);
      drive(1'b0, 1'b0, 1'b0, '0);
    end
    for (int k = 0; k < nw; k++) begin
      while (($urandom % 100) < gap_pct) begin
        @(negedge clk);
        if (pend) chk(crc_o == held, "R4", "gap changed crc", {32'b0, crc_o}, {32'b0, held});
        held = crc_o;
        pend = 1'b1;
        drive(1'b0, 1'b0, 1'b1, {$urandom, $urandom});
      end
      @(negedge clk);
      if (pend) chk(crc_o == held, "R4", "gap changed crc", {32'b0, crc_o}, {32'b0, held});
      pend = 1'b0;
      w = {$urandom, $urandom};
      for (int b = 63; b >= 0; b--) gold = step(gold, w[b]);
      drive(1'b0, 1'b1, (k == nw - 1), w);
    end
    for (int b = 0; b < 32; b++) gold = step(gold, 1'b0);
    @(negedge clk);
    chk(done_o == 1'b0, "R5", "done before padding", {63'b0, done_o}, 64'b0);
    drive(1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
    chk(done_o == 1'b1, "R5", "done after padding", {63'b0, done_o}, 64'b1);
    chk(crc_o == gold, "R5", "message remainder", {32'b0, crc_o}, {32'b0, gold});
    @(negedge clk);
    chk(done_o == 1'b0, "R6", "done longer than one cycle", {63'b0, done_o}, 64'b0);
  endtask

  initial begin
    logic [31:0] g;
    n_tests  = 0;
    n_fail   = 0;
    finished = 1'b0;
    cmp_en   = 1'b0;
    rst_n    = 1'b0;
    drive(1'b0, 1'b0, 1'b0, '0);
    repeat (3) @(negedge clk);
    chk(crc_o == '0, "R1", "crc during reset", {32'b0, crc_o}, 64'b0);
    chk(done_o == 1'b0, "R1", "done during reset", {63'b0, done_o}, 64'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(crc_o == '0, "R1", "crc after reset", {32'b0, crc_o}, 64'b0);
    cmp_en = 1'b1;

    // R8: words before any start
    for (int k = 0; k < 5; k++) begin
      drive(1'b0, 1'b1, k[0], {$urandom, $urandom});
      @(negedge clk);
      chk(crc_o == '0, "R8", "word before first start", {32'b0, crc_o}, 64'b0);
    end

    send(1, 0, 1'b0, g);
    send(2, 0, 1'b0, g);
    send(3, 40, 1'b0, g);
    send(7, 30, 1'b0, g);

    // R7: traffic after done leaves the result alone
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, 1'b1, k[0], {$urandom, $urandom});
      @(negedge clk);
      chk(crc_o == g, "R7", "crc after done", {32'b0, crc_o}, {32'b0, g});
    end

    send(4, 0, 1'b1, g);  // R2 start beside a valid word

    // R9: abandon a message midway, then a fresh one
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, '0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      drive(1'b0, 1'b1, 1'b0, {$urandom, $urandom});
    end
    send(5, 20, 1'b0, g);
    chk(crc_o == g, "R9", "restart kept old state", {32'b0, crc_o}, {32'b0, g});

    send(1, 50, 1'b0, g);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule